// File: doc/BRIEF.md
# Loadable Add/Subtract Accumulator Register

This block is a clocked arithmetic register. It holds a W-bit value `q` and, on each enabled clock, replaces it with one of four results built from `q` and the W-bit operand `din`: the operand itself, the operand negated, the sum `q + din`, or the difference `q - din`. Two plain control pins pick the result. `accum` chooses between starting afresh and folding the operand into the stored value. `neg` chooses between adding and subtracting.

In the fresh modes the stored value is replaced by zero in front of the adder. The load and negate-load modes therefore use the same adder as accumulation, and their carry and overflow are the true flags of `0 ± din`. A synchronous clear has priority over a synchronous fill, and both take priority over the arithmetic path.

Every result is registered together with a carry/borrow bit and a signed-overflow bit. The flags always describe the operation that produced the current `q`.

The operand is qualified by `en` alone. The register accepts a new operand on every enabled cycle and never applies back-pressure, so no ready signal exists.

Top module: `accum_reg`

## Requirements
- R1: When `srst` is 1 at a rising edge, `q`, `cout` and `ovf` are all 0 after that edge, whatever the other inputs are.
- R2: When `srst` is 0 and `sset` is 1 at a rising edge, `q` becomes all ones and `cout` and `ovf` become 0, whatever `en` is.
- R3: When `srst`, `sset` and `en` are all 0 at a rising edge, `q`, `cout` and `ovf` keep their values.
- R4: With `en` = 1, `accum` = 0 and `neg` = 0, the next `q` equals `din`.
- R5: With `en` = 1, `accum` = 0 and `neg` = 1, the next `q` equals the two's complement negation of `din`, modulo 2^W.
- R6: With `en` = 1, `accum` = 1 and `neg` = 0, the next `q` equals `q + din` modulo 2^W.
- R7: With `en` = 1, `accum` = 1 and `neg` = 1, the next `q` equals `q - din` modulo 2^W.
- R8: In the add modes, `cout` is set to bit W of the (W+1)-bit unsigned sum of the zero-extended operands. In the subtract modes, `cout` is a borrow: it is 1 exactly when the first operand (`q` when accumulating, 0 when loading) is below `din` as an unsigned number.
- R9: `ovf` is set to 1 exactly when the true signed result of the selected operation, on two's complement operands, lies outside [-2^(W-1), 2^(W-1)-1]. Negating the most negative value raises `ovf` and leaves `q` at that same most negative value.
- R10: `cout` and `ovf` update only on the edges where `q` takes an arithmetic result, and they are registered together with `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous clear, highest priority |
| sset | input | 1 | Synchronous fill to all ones |
| en | input | 1 | Clock enable for the arithmetic update |
| accum | input | 1 | 1 = combine with `q`, 0 = start from zero |
| neg | input | 1 | 1 = subtract, 0 = add |
| din | input | W | Operand |
| q | output | W | Stored value |
| cout | output | 1 | Carry (add) or borrow (subtract) of the last result |
| ovf | output | 1 | Signed overflow of the last result |

## Verification
Any corruption of the stored value appears on `q` one cycle after the edge that caused it. It also propagates into every later accumulated result, so a stale or wrong `q` is never masked. A wrong flag is visible in the same cycle as the result it belongs to. The bench compares all three outputs against an integer model after every edge, so a fault in operand zeroing, carry polarity or overflow detection is reported at the first operation that exposes it. The corner operands (zero, all ones, the extremes of the signed range) are driven in both load and accumulate modes.

// File: rtl/accum_pkg.sv
package accum_pkg;
  typedef enum logic [1:0] {
    OP_LOAD    = 2'b00,
    OP_LOADNEG = 2'b01,
    OP_ADD     = 2'b10,
    OP_SUB     = 2'b11
  } op_e;

  typedef struct packed {
    logic carry;
    logic ovf;
  } flags_t;
endpackage

// File: rtl/accum_operand_gate.sv
module accum_operand_gate #(
  parameter int W = 8
) (
  input  logic [W-1:0] stored,
  input  logic         accum,
  output logic [W-1:0] opa
);
  // Fresh modes start from zero so the adder also yields honest flags.
  always_comb opa = accum ? stored : '0;
endmodule

// File: rtl/accum_addsub_core.sv
module accum_addsub_core #(
  parameter int W = 8
) (
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  input  logic           sub,
  output logic [W-1:0]   res,
  output accum_pkg::flags_t flg
);
  logic [W:0]   c;
  logic [W-1:0] bx;

  assign c[0] = sub;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign bx[i]   = opb[i] ^ sub;
      assign res[i]  = opa[i] ^ bx[i] ^ c[i];
      assign c[i+1]  = (opa[i] & bx[i]) | (c[i] & (opa[i] ^ bx[i]));
    end
  endgenerate

  // Subtract reports a borrow: the inverted carry out of the chain.
  always_comb begin
    flg.carry = c[W] ^ sub;
    flg.ovf   = c[W] ^ c[W-1];
  end
endmodule

// File: rtl/accum_reg.sv
module accum_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         srst,
  input  logic         sset,
  input  logic         en,
  input  logic         accum,
  input  logic         neg,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         cout,
  output logic         ovf
);
  import accum_pkg::*;

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  op_e          op;
  logic [W-1:0] opa;
  logic [W-1:0] nxt;
  flags_t       nflg;

  assign op = op_e'({accum, neg});

  accum_operand_gate #(.W(W)) u_gate (
    .stored (q),
    .accum  (op == OP_ADD || op == OP_SUB),
    .opa    (opa)
  );

  accum_addsub_core #(.W(W)) u_core (
    .opa (opa),
    .opb (din),
    .sub (op == OP_LOADNEG || op == OP_SUB),
    .res (nxt),
    .flg (nflg)
  );

  always_ff @(posedge clk) begin
    if (srst) begin
      q    <= '0;
      cout <= 1'b0;
      ovf  <= 1'b0;
    end else if (sset) begin
      q    <= '1;
      cout <= 1'b0;
      ovf  <= 1'b0;
    end else if (en) begin
      q    <= nxt;
      cout <= nflg.carry;
      ovf  <= nflg.ovf;
    end
  end

  assert_clear_R1: assert property (@(posedge clk)
    srst |=> (q == '0 && !cout && !ovf));

  assert_fill_R2: assert property (@(posedge clk) disable iff (srst)
    sset |=> (q == '1 && !cout && !ovf));

  assert_hold_R3: assert property (@(posedge clk) disable iff (srst)
    (!sset && !en) |=> ($stable(q) && $stable(cout) && $stable(ovf)));

  assert_load_R4: assert property (@(posedge clk) disable iff (srst)
    (!sset && en && !accum && !neg) |=> (q == $past(din)));

  assert_loadneg_R5: assert property (@(posedge clk) disable iff (srst)
    (!sset && en && !accum && neg) |=> (q == W'(0 - $past(din))));

  assert_add_R6: assert property (@(posedge clk) disable iff (srst)
    (!sset && en && accum && !neg) |=> (q == W'($past(q) + $past(din))));

  assert_sub_R7: assert property (@(posedge clk) disable iff (srst)
    (!sset && en && accum && neg) |=> (q == W'($past(q) - $past(din))));

  assert_borrow_R8: assert property (@(posedge clk) disable iff (srst)
    (!sset && en && accum && neg) |=> (cout == ($past(q) < $past(din))));

  assert_negmin_R9: assert property (@(posedge clk) disable iff (srst)
    (!sset && en && !accum && neg && din == MOST_NEG) |=> (ovf && q == MOST_NEG));
endmodule

// File: tb/accum_reg_bench.sv
module accum_reg_bench;
  localparam int W = 8;
  localparam int MOD = 1 << W;
  localparam int HALF = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         srst = 1'b1, sset = 1'b0, en = 1'b0, accum = 1'b0, neg = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic         cout, ovf;

  int total = 0, bad = 0;
  int mq = 0, mc = 0, mo = 0;
  string tag = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  accum_reg #(.W(W)) u_accum_reg (
    .clk(clk), .srst(srst), .sset(sset), .en(en), .accum(accum),
    .neg(neg), .din(din), .q(q), .cout(cout), .ovf(ovf)
  );

  function automatic int to_signed(int v);
    return (v >= HALF) ? v - MOD : v;
  endfunction

  // Behavioural reference, one step per rising edge.
  always @(posedge clk) begin
    int a, ur, sr;
    if (srst) begin
      mq = 0; mc = 0; mo = 0; tag = "R1";
    end else if (sset) begin
      mq = MOD - 1; mc = 0; mo = 0; tag = "R2";
    end else if (en) begin
      a = accum ? mq : 0;
      if (neg) begin
        ur = a - int'(din);
        mc = (ur < 0) ? 1 : 0;
        sr = to_signed(a) - to_signed(int'(din));
      end else begin
        ur = a + int'(din);
        mc = (ur >= MOD) ? 1 : 0;
        sr = to_signed(a) + to_signed(int'(din));
      end
      mo = (sr > HALF - 1 || sr < -HALF) ? 1 : 0;
      mq = ((ur % MOD) + MOD) % MOD;
      tag = accum ? (neg ? "R7" : "R6") : (neg ? "R5" : "R4");
    end else begin
      tag = "R3";
    end
  end

  task automatic check_now();
    total++;
    if (int'(q) != mq) begin
      bad++;
      $display("FAIL %s q actual=%0d expected=%0d", tag, q, mq);
    end
    total++;
    if (int'(cout) != mc) begin
      bad++;
      $display("FAIL R8/R10 (%s) cout actual=%0d expected=%0d", tag, cout, mc);
    end
    total++;
    if (int'(ovf) != mo) begin
      bad++;
      $display("FAIL R9/R10 (%s) ovf actual=%0d expected=%0d", tag, ovf, mo);
    end
  endtask

  task automatic step(bit r, bit s, bit e, bit acc, bit n, logic [W-1:0] d);
    srst = r; sset = s; en = e; accum = acc; neg = n; din = d;
    @(negedge clk);
    check_now();
  endtask

  initial begin
    logic [W-1:0] corners [4];
    corners[0] = '0; corners[1] = '1;
    corners[2] = W'(HALF - 1); corners[3] = W'(HALF);
    repeat (3) @(negedge clk);
    step(1, 0, 0, 0, 0, 0);                 // R1 reset state
    step(0, 0, 1, 0, 1, W'(HALF));          // R5 / R9: negate most negative
    step(0, 0, 0, 1, 0, 8'h55);             // R3 hold keeps flags
    step(0, 1, 1, 1, 1, 8'h12);             // R2 fill beats enable
    step(1, 1, 1, 0, 0, 8'h34);             // R1 clear beats fill
    step(0, 0, 1, 0, 1, 0);                 // R5 negate zero, no borrow (R8)
    step(0, 0, 1, 0, 0, '1);                // R4
    step(0, 0, 1, 1, 0, 8'h01);             // R6 wrap with carry (R8)
    step(0, 0, 1, 1, 1, 8'h01);             // R7 borrow (R8)
    for (int m = 0; m < 4; m++)
      for (int x = 0; x < 4; x++)
        for (int y = 0; y < 4; y++) begin
          step(0, 0, 1, 0, 0, corners[x]);
          step(0, 0, 1, m[1], m[0], corners[y]);
        end
    for (int k = 0; k < 2000; k++) begin
      int r = $urandom_range(0, 99);
      step(r < 2, r >= 2 && r < 4, $urandom_range(0, 3) != 0,
           1'($urandom), 1'($urandom), W'($urandom));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule